// File: doc/BRIEF.md
# Two-Bit Branch History Table

This block predicts the direction of conditional branches. It holds one table of two-bit saturating counters, chosen by a few low bits of the branch address, with no tag. The fetch stage presents a PC on the lookup port and receives a taken or not-taken guess in the same cycle. The branch unit later reports the resolved PC and its real outcome on the update port. The matching counter then moves one step toward that outcome, and the block reports at once whether the stored guess was wrong.

The counter provides hysteresis. An entry that sits in a strong state must see two opposite outcomes in a row before its guess changes. A loop-closing branch that falls through once therefore keeps its taken guess.

Both ports carry a valid strobe and have no ready signal. The table accepts a lookup and an update in every cycle, so neither side ever sees back-pressure. The lookup answer qualifier, `pred_valid`, follows `lk_valid` in the same cycle.

Top module: `branch_history_table`

## Requirements
- R1: After reset every entry holds state 01, so every lookup predicts not taken, and a single taken update makes that entry predict taken.
- R2: A lookup is answered in the cycle it is presented: `pred_valid` equals `lk_valid`, and `pred_taken` reflects all updates applied at earlier clock edges.
- R3: The entry index is `pc[IDX_W+1:2]` with IDX_W = log2(ENTRIES). PC bits [1:0] and all bits above the index are ignored, so addresses that differ only there share one entry.
- R4: Counter states 00 and 01 predict not taken; states 10 and 11 predict taken.
- R5: A taken outcome moves the counter up by one and a not-taken outcome moves it down by one, holding at 11 and at 00.
- R6: `up_mispredict` is high only when `up_valid` is high and the entry's prediction before the update differs from `up_taken`.
- R7: From a strong state (00 or 11), one opposite outcome leaves the prediction unchanged, and a second consecutive opposite outcome flips it.
- R8: When a lookup and an update select the same entry in one cycle, the lookup returns the value from before that update.
- R9: While `up_valid` is low, `up_pc` and `up_taken` change no entry.
- R10: An update changes only the entry its index selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_pc | input | PC_W | Fetch address to predict |
| pred_valid | output | 1 | Prediction qualifier, same cycle as lk_valid |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Resolved-branch strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_mispredict | output | 1 | Stored guess disagreed with up_taken |

## Verification
A corrupted counter does not show at once. It reaches the ports only when its entry is next looked up or updated, as a wrong `pred_taken` or a wrong `up_mispredict` in that same cycle. A wrong step or a wrong saturation value can stay hidden for one or two further updates, until the counter crosses the taken/not-taken boundary at the wrong point. For this reason the bench tracks every counter and checks the lookup and update results in every cycle over long mixed sequences. Directed sequences drive each entry into and out of both saturated states. Index and aliasing faults show up when a write lands in one entry and is read back through a different one.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;
  localparam ctr_t CTR_MAX   = 2'b11;
  localparam ctr_t CTR_MIN   = 2'b00;

  // Upper bit of the counter carries the direction.
  function automatic logic ctr_predicts(input ctr_t c);
    return c[1];
  endfunction

  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t n;
    n = c;
    if (taken) begin
      if (c != CTR_MAX) n = c + 2'd1;
    end else begin
      if (c != CTR_MIN) n = c - 2'd1;
    end
    return n;
  endfunction
endpackage

// File: rtl/bht_index.sv
module bht_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  // Word aligned instructions: bits [1:0] carry no information.
  localparam int LSB = 2;

  assign idx = pc[IDX_W+LSB-1:LSB];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[PC_W-1:IDX_W+LSB], pc[LSB-1:0]};
endmodule

// File: rtl/bht_ctr_array.sv
module bht_ctr_array
  import bht_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output ctr_t             rd_a_ctr,
  input  logic [IDX_W-1:0] rd_b_idx,
  output ctr_t             rd_b_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_ctr
);
  ctr_t cells [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells[g] <= CTR_RESET;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        cells[g] <= wr_ctr;
      end
    end
  end

  // Reads see the stored value, never the write in flight.
  assign rd_a_ctr = cells[rd_a_idx];
  assign rd_b_ctr = cells[rd_b_idx];
endmodule

// File: rtl/bht_resolve.sv
module bht_resolve
  import bht_pkg::*;
(
  input  logic valid,
  input  ctr_t cur,
  input  logic taken,
  output ctr_t nxt,
  output logic wrong
);
  assign nxt   = ctr_step(cur, taken);
  assign wrong = valid && (ctr_predicts(cur) != taken);
endmodule

// File: rtl/branch_history_table.sv
module branch_history_table
  import bht_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  output logic            up_mispredict
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] lk_idx, up_idx;
  ctr_t             lk_ctr, up_ctr, up_next;

  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_index (.pc(lk_pc), .idx(lk_idx));
  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_index (.pc(up_pc), .idx(up_idx));

  bht_ctr_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (lk_idx),
    .rd_a_ctr (lk_ctr),
    .rd_b_idx (up_idx),
    .rd_b_ctr (up_ctr),
    .wr_en    (up_valid),
    .wr_idx   (up_idx),
    .wr_ctr   (up_next)
  );

  bht_resolve u_resolve (
    .valid (up_valid),
    .cur   (up_ctr),
    .taken (up_taken),
    .nxt   (up_next),
    .wrong (up_mispredict)
  );

  assign pred_valid = lk_valid;
  assign pred_taken = ctr_predicts(lk_ctr);
endmodule

// File: rtl/bht_checker.sv
module bht_checker #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic [PC_W-1:0] lk_pc,
  input logic            pred_taken,
  input logic            up_valid,
  input logic [PC_W-1:0] up_pc,
  input logic            up_taken,
  input logic            up_mispredict
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] c_lk_idx, c_up_idx;
  assign c_lk_idx = lk_pc[IDX_W+1:2];
  assign c_up_idx = up_pc[IDX_W+1:2];

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_reset_weak_nt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0 && lk_valid) |-> !pred_taken);

  assert_flag_needs_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    up_mispredict |-> up_valid);

  assert_same_cycle_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && up_valid && c_lk_idx == c_up_idx) |-> (pred_taken == (up_taken ^ up_mispredict)));

  assert_confirmed_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && up_valid && !up_mispredict) |=>
      (!(lk_valid && c_lk_idx == $past(c_up_idx)) || pred_taken == $past(up_taken)));

  assert_two_misses_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && up_valid && up_mispredict && $past(up_valid && up_mispredict)
      && c_up_idx == $past(c_up_idx) && up_taken == $past(up_taken)) |=>
      (!(lk_valid && c_lk_idx == $past(c_up_idx)) || pred_taken == $past(up_taken)));
endmodule

bind branch_history_table bht_checker #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_bht_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_valid      (lk_valid),
  .lk_pc         (lk_pc),
  .pred_taken    (pred_taken),
  .up_valid      (up_valid),
  .up_pc         (up_pc),
  .up_taken      (up_taken),
  .up_mispredict (up_mispredict)
);

// File: tb/test_branch_history_table.sv
`timescale 1ns/1ps
module test_branch_history_table;
  localparam int PC_W = 12;
  localparam int ENTRIES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, up_valid = 1'b0, up_taken = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
  logic pred_valid, pred_taken, up_mispredict;

  int checks = 0;
  int fails = 0;
  int model [ENTRIES];

  always #2.5 clk = ~clk;

  branch_history_table #(.PC_W(PC_W), .ENTRIES(ENTRIES)) i_branch_history_table (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .pred_valid(pred_valid), .pred_taken(pred_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_mispredict(up_mispredict)
  );

  function automatic int ix(input logic [PC_W-1:0] p);
    return int'((p >> 2) % ENTRIES);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive after the falling edge, check the same-cycle outputs,
  // then let the rising edge commit and advance the model.
  task automatic cyc(input string req, input logic lv, input logic [PC_W-1:0] lp,
                     input logic uv, input logic [PC_W-1:0] upc, input logic ut);
    @(negedge clk);
    lk_valid = lv; lk_pc = lp; up_valid = uv; up_pc = upc; up_taken = ut;
    #1;
    check({req, " R2 valid"}, pred_valid, lv);
    if (lv) check({req, " R4 prediction"}, pred_taken, model[ix(lp)] >= 2);
    check({req, " R6 mispredict"}, up_mispredict, uv && ((model[ix(upc)] >= 2) != ut));
    @(posedge clk);
    if (uv) begin
      if (ut && model[ix(upc)] < 3) model[ix(upc)]++;
      if (!ut && model[ix(upc)] > 0) model[ix(upc)]--;
    end
  endtask

  function automatic logic [PC_W-1:0] pc_of(input int e, input int hi, input int lo);
    return PC_W'((hi << (2 + $clog2(ENTRIES))) | (e << 2) | lo);
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int e = 0; e < ENTRIES; e++) model[e] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every entry weakly not taken after reset
    for (int e = 0; e < ENTRIES; e++) cyc("R1 reset", 1'b1, pc_of(e, 0, 0), 1'b0, '0, 1'b0);
    // R1: one taken update flips a weak entry
    cyc("R1 flip", 1'b0, '0, 1'b1, pc_of(3, 0, 0), 1'b1);
    cyc("R1 flip", 1'b1, pc_of(3, 0, 0), 1'b0, '0, 1'b0);
    check("R1 taken after one update", pred_taken, 1'b1);

    // R5/R7: saturate entry 5 high, then two not-taken outcomes
    for (int k = 0; k < 5; k++) cyc("R5 saturate up", 1'b1, pc_of(5, 0, 0), 1'b1, pc_of(5, 0, 0), 1'b1);
    cyc("R7 first miss", 1'b1, pc_of(5, 0, 0), 1'b1, pc_of(5, 0, 0), 1'b0);
    cyc("R7 still taken", 1'b1, pc_of(5, 0, 0), 1'b0, '0, 1'b0);
    check("R7 one miss keeps taken", pred_taken, 1'b1);
    cyc("R7 second miss", 1'b0, '0, 1'b1, pc_of(5, 0, 0), 1'b0);
    cyc("R7 flipped", 1'b1, pc_of(5, 0, 0), 1'b0, '0, 1'b0);
    check("R7 two misses flip", pred_taken, 1'b0);
    // R5: saturate low and climb back
    for (int k = 0; k < 5; k++) cyc("R5 saturate down", 1'b1, pc_of(6, 0, 0), 1'b1, pc_of(6, 0, 0), 1'b0);
    cyc("R7 low miss1", 1'b1, pc_of(6, 0, 0), 1'b1, pc_of(6, 0, 0), 1'b1);
    cyc("R7 low miss2", 1'b1, pc_of(6, 0, 0), 1'b1, pc_of(6, 0, 0), 1'b1);
    cyc("R7 low flipped", 1'b1, pc_of(6, 0, 0), 1'b0, '0, 1'b0);

    // R3: aliasing through high bits and low two bits
    cyc("R3 alias write", 1'b0, '0, 1'b1, pc_of(2, 5, 3), 1'b1);
    cyc("R3 alias read", 1'b1, pc_of(2, 1, 1), 1'b0, '0, 1'b0);
    check("R3 aliased entry taken", pred_taken, 1'b1);

    // R8: same-cycle lookup and update of the same entry sees the old value
    cyc("R8 same cycle", 1'b1, pc_of(4, 0, 0), 1'b1, pc_of(4, 2, 0), 1'b1);
    check("R8 old value", pred_taken, 1'b0);
    cyc("R8 after", 1'b1, pc_of(4, 0, 0), 1'b0, '0, 1'b0);

    // R9: idle update port with moving data changes nothing
    for (int k = 0; k < 16; k++) cyc("R9 idle", 1'b0, '0, 1'b0, PC_W'(k * 4), k[0]);
    for (int e = 0; e < ENTRIES; e++) cyc("R9 readback", 1'b1, pc_of(e, 0, 0), 1'b0, '0, 1'b0);

    // R10 and all: long mixed sweep against the model
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc("R10 sweep", lfsr[0], PC_W'(lfsr[15:4]), lfsr[1] | lfsr[2], PC_W'({lfsr[7:0], lfsr[11:8]}),
          lfsr[3] ^ (lfsr[9] & lfsr[14]));
    end
    for (int e = 0; e < ENTRIES; e++) cyc("R10 final", 1'b1, pc_of(e, 3, 2), 1'b0, '0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule